// File: doc/BRIEF.md
# Dual-Product Packed Squarer

This block squares two small independent numbers with one signed multiply. A signed value X and an unsigned value Y are packed into a single multiplier operand: X sits in the top field, Y in the bottom field, and a band of zero bits separates them. The same packed word feeds both inputs of the multiplier. The full product then holds three terms: X squared at the top, Y squared at the bottom, and twice X times Y in a middle band that is discarded.

With the default sizes the operand is 18 bits wide. X is 6 bits signed at operand bits [17:12], Y is 5 bits unsigned at bits [4:0], and bits [11:5] are zero. This places X squared in product bits [35:24] and Y squared in product bits [9:0]. When X is negative the cross term is negative, and it borrows one unit from the top field. The block reads that borrow from the sign bit of the discarded band (product bit 23) and adds it back, so the X-squared result is exact for every input pair.

An option registers the results. When it is on, the outputs update one cycle after the input and the output valid follows the input valid. When it is off, the path is purely combinational.

Top module: `dps_packed_squarer`

## Requirements
- R1: `ysq_out` equals Y*Y as a 10-bit unsigned value for every Y in 0..31 and every X.
- R2: `xsq_out` equals X*X as a 12-bit non-negative value for every X in -32..31 and every Y. This includes negative X with nonzero Y, where the packed product borrows from the top field.
- R3: With Y = 0, `xsq_out` equals X*X and `ysq_out` is 0.
- R4: With X = 0, `xsq_out` is 0 and `ysq_out` equals Y*Y.
- R5: With `REG_OUT` = 0, the outputs reflect the current inputs in the same cycle and `out_vld` equals `in_vld`.
- R6: With `REG_OUT` = 1, results appear one rising edge after the input is presented, and `out_vld` equals `in_vld` from the previous edge.
- R7: With `REG_OUT` = 1, a cycle with `in_vld` low leaves `xsq_out` and `ysq_out` unchanged, whatever X and Y are.
- R8: With `REG_OUT` = 1, while `rst_n` is low, `out_vld`, `xsq_out` and `ysq_out` are all 0.
- R9: Whenever `out_vld` is high, `xsq_out` is at most 1024 and `ysq_out` is at most 961.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 1 | Input pair is valid |
| x_in | input | XW (6) | Signed value X (two's complement) |
| y_in | input | YW (5) | Unsigned value Y |
| out_vld | output | 1 | Results are valid |
| xsq_out | output | 2*XW (12) | X squared, non-negative |
| ysq_out | output | 2*YW (10) | Y squared, unsigned |

## Verification
Every one of the 2048 input pairs is applied to both the combinational and the registered variant, and the outputs are compared against squares computed arithmetically in the bench.

Errors in this block show up at once, in the very cycle of the offending pair. A wrong field boundary or a missing guard gap corrupts every nonzero pair. A missing or misplaced borrow correction shows up only for negative X with nonzero Y, and there `xsq_out` reads exactly one less than X*X. Because of this narrow signature the sweep covers all pairs rather than a sample.

A latch enable or valid pipeline that is off by one shows up on the first held cycle or the first cycle after reset, where stale or early data appears at the registered outputs.

// File: rtl/dps_pkg.sv
package dps_pkg;

   // 2**n as a 64-bit quantity, usable in constant expressions
   function automatic longint pow2(input int n);
      return longint'(64'(1) << n);
   endfunction

   // largest square of an unsigned yw-bit value
   function automatic longint usq_max(input int yw);
      return (pow2(yw) - 1) * (pow2(yw) - 1);
   endfunction

   // largest magnitude of the middle (cross) term for a given packing
   function automatic longint cross_max(input int xw, input int yw, input int sh);
      return pow2(xw - 1) * (pow2(yw) - 1) * pow2(sh + 1);
   endfunction

endpackage

// File: rtl/dps_operand_pack.sv
module dps_operand_pack #(
   parameter int XW = 6,
   parameter int YW = 5,
   parameter int MW = 18
) (
   input  logic [XW-1:0] x_val,
   input  logic [YW-1:0] y_val,
   output logic [MW-1:0] opnd
);
   localparam int GAP = MW - XW - YW;

   generate
      if (GAP > 0) begin : g_gap
         assign opnd = {x_val, {GAP{1'b0}}, y_val};
      end else begin : g_nogap
         assign opnd = {x_val, y_val};
      end
   endgenerate
endmodule

// File: rtl/dps_mult.sv
module dps_mult #(
   parameter int MW = 18
) (
   input  logic [MW-1:0]   a,
   input  logic [MW-1:0]   b,
   output logic [2*MW-1:0] p
);
   logic signed [2*MW-1:0] a_ext;
   logic signed [2*MW-1:0] b_ext;

   assign a_ext = {{MW{a[MW-1]}}, a};
   assign b_ext = {{MW{b[MW-1]}}, b};
   assign p     = a_ext * b_ext;
endmodule

// File: rtl/dps_field_extract.sv
module dps_field_extract #(
   parameter int XW = 6,
   parameter int YW = 5,
   parameter int MW = 18
) (
   input  logic [2*MW-1:0] prod,
   output logic [2*XW-1:0] xsq,
   output logic [2*YW-1:0] ysq
);
   localparam int SH   = MW - XW;        // weight of X inside the operand
   localparam int HI_LO = 2 * SH;        // first bit of the X-squared field
   localparam int MID_TOP = HI_LO - 1;   // sign of the discarded band

   logic [2*XW-1:0] hi_raw;
   logic            borrow;
   logic            unused_mid;

   assign hi_raw = prod[2*MW-1 -: 2*XW];
   // a negative cross term pulls one unit out of the top field;
   // the band's sign bit tells whether that happened
   assign borrow = prod[MID_TOP];
   assign xsq    = hi_raw + {{(2*XW-1){1'b0}}, borrow};
   assign ysq    = prod[2*YW-1:0];

   assign unused_mid = ^prod[MID_TOP-1:2*YW];
endmodule

// File: rtl/dps_packed_squarer.sv
module dps_packed_squarer
   import dps_pkg::*;
#(
   parameter int XW      = 6,
   parameter int YW      = 5,
   parameter int MW      = 18,
   parameter bit REG_OUT = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_vld,
   input  logic [XW-1:0]   x_in,
   input  logic [YW-1:0]   y_in,
   output logic            out_vld,
   output logic [2*XW-1:0] xsq_out,
   output logic [2*YW-1:0] ysq_out
);
   localparam int     SH       = MW - XW;
   localparam int     GAP      = SH - YW;
   localparam longint YSQ_MAX  = usq_max(YW);
   localparam longint XSQ_MAX  = pow2(2 * (XW - 1));
   localparam longint CROSS_LO = pow2(SH + 1);
   localparam longint CROSS_HI = cross_max(XW, YW, SH);
   localparam longint BAND_LIM = pow2(2 * SH - 1);

   // elaboration-time checks on the packing
   if (XW < 2 || YW < 1) begin : g_bad_width
      $error("dps_packed_squarer: XW must be >= 2 and YW >= 1");
   end
   if (GAP < 0) begin : g_bad_fit
      $error("dps_packed_squarer: X and Y fields do not fit in MW");
   end
   if (!(CROSS_LO > YSQ_MAX)) begin : g_bad_low
      $error("dps_packed_squarer: cross term overlaps the Y-squared field");
   end
   if (!(CROSS_HI + YSQ_MAX < BAND_LIM)) begin : g_bad_high
      $error("dps_packed_squarer: cross term reaches the X-squared field");
   end

   logic [MW-1:0]   opnd;
   logic [2*MW-1:0] prod;
   logic [2*XW-1:0] xsq_c;
   logic [2*YW-1:0] ysq_c;

   dps_operand_pack #(.XW(XW), .YW(YW), .MW(MW)) u_pack (
      .x_val (x_in),
      .y_val (y_in),
      .opnd  (opnd)
   );

   dps_mult #(.MW(MW)) u_mult (
      .a (opnd),
      .b (opnd),
      .p (prod)
   );

   dps_field_extract #(.XW(XW), .YW(YW), .MW(MW)) u_extract (
      .prod (prod),
      .xsq  (xsq_c),
      .ysq  (ysq_c)
   );

   generate
      if (REG_OUT) begin : g_reg
         logic            vld_q;
         logic [2*XW-1:0] xsq_q;
         logic [2*YW-1:0] ysq_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               vld_q <= 1'b0;
               xsq_q <= '0;
               ysq_q <= '0;
            end else begin
               vld_q <= in_vld;
               if (in_vld) begin
                  xsq_q <= xsq_c;
                  ysq_q <= ysq_c;
               end
            end
         end

         assign out_vld = vld_q;
         assign xsq_out = xsq_q;
         assign ysq_out = ysq_q;

         a_r6_vld_delay: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> out_vld == $past(in_vld));
         a_r2_xsq_exact: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) && $past(in_vld) |->
               longint'(xsq_out) ==
               longint'($past($signed(x_in))) * longint'($past($signed(x_in))));
         a_r1_ysq_exact: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) && $past(in_vld) |->
               longint'(ysq_out) == longint'($past(y_in)) * longint'($past(y_in)));
         a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) && !$past(in_vld) |-> $stable(xsq_out) && $stable(ysq_out));
      end else begin : g_comb
         assign out_vld = in_vld;
         assign xsq_out = xsq_c;
         assign ysq_out = ysq_c;

         a_r2_xsq_exact: assert property (@(posedge clk) disable iff (!rst_n)
            in_vld |-> longint'(xsq_out) ==
               longint'($signed(x_in)) * longint'($signed(x_in)));
         a_r1_ysq_exact: assert property (@(posedge clk) disable iff (!rst_n)
            in_vld |-> longint'(ysq_out) == longint'(y_in) * longint'(y_in));
      end
   endgenerate

   a_r9_range: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld |-> longint'(xsq_out) <= XSQ_MAX && longint'(ysq_out) <= YSQ_MAX);
endmodule

// File: tb/dps_packed_squarer_tb.sv
module dps_packed_squarer_tb_top;
   localparam int XW = 6;
   localparam int YW = 5;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            in_vld = 1'b0;
   logic [XW-1:0]   x_in = '0;
   logic [YW-1:0]   y_in = '0;
   logic            r_vld, c_vld;
   logic [2*XW-1:0] r_xsq, c_xsq;
   logic [2*YW-1:0] r_ysq, c_ysq;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   dps_packed_squarer #(.XW(XW), .YW(YW), .MW(18), .REG_OUT(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .x_in(x_in), .y_in(y_in),
      .out_vld(r_vld), .xsq_out(r_xsq), .ysq_out(r_ysq)
   );

   dps_packed_squarer #(.XW(XW), .YW(YW), .MW(18), .REG_OUT(1'b0)) dut_c_i (
      .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .x_in(x_in), .y_in(y_in),
      .out_vld(c_vld), .xsq_out(c_xsq), .ysq_out(c_ysq)
   );

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin : watchdog
      #(8 * 150000);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=timeout expected=completion");
         finish_run();
      end
   end

   initial begin : stim
      int px, py;
      // R8: reset state of the registered variant
      repeat (3) @(posedge clk);
      @(negedge clk);
      in_vld = 1'b1; x_in = 6'h2A; y_in = 5'd17;
      #1;
      chk("R8 out_vld in reset", int'(r_vld), 0);
      chk("R8 xsq_out in reset", int'(r_xsq), 0);
      chk("R8 ysq_out in reset", int'(r_ysq), 0);
      @(posedge clk); #1;
      chk("R8 xsq_out held in reset", int'(r_xsq), 0);
      @(negedge clk);
      in_vld = 1'b0;
      rst_n  = 1'b1;

      px = 0; py = 0;
      for (int xi = -32; xi < 32; xi++) begin
         for (int yi = 0; yi < 32; yi++) begin
            @(negedge clk);
            x_in   = xi[XW-1:0];
            y_in   = yi[YW-1:0];
            in_vld = 1'b1;
            #1;
            // R5: combinational variant follows at once
            chk("R5 comb out_vld", int'(c_vld), 1);
            chk("R2 comb xsq", int'(c_xsq), xi * xi);
            chk("R1 comb ysq", int'(c_ysq), yi * yi);
            if (yi == 0) chk("R3 comb ysq with y=0", int'(c_ysq), 0);
            if (xi == 0) chk("R4 comb xsq with x=0", int'(c_xsq), 0);
            // R6: registered variant still shows the previous pair
            if (!(xi == -32 && yi == 0)) begin
               chk("R6 reg xsq before edge", int'(r_xsq), px * px);
               chk("R6 reg ysq before edge", int'(r_ysq), py * py);
            end
            @(posedge clk); #1;
            chk("R6 reg out_vld", int'(r_vld), 1);
            chk("R2 reg xsq", int'(r_xsq), xi * xi);
            chk("R1 reg ysq", int'(r_ysq), yi * yi);
            if (yi == 0) begin
               chk("R3 reg xsq with y=0", int'(r_xsq), xi * xi);
               chk("R3 reg ysq with y=0", int'(r_ysq), 0);
            end
            if (xi == 0) begin
               chk("R4 reg xsq with x=0", int'(r_xsq), 0);
               chk("R4 reg ysq with x=0", int'(r_ysq), yi * yi);
            end
            chk("R9 reg xsq bound", int'(r_xsq <= 12'd1024), 1);
            chk("R9 reg ysq bound", int'(r_ysq <= 10'd961), 1);
            px = xi; py = yi;
         end
      end

      // R7: invalid cycles do not disturb the registered results
      @(negedge clk);
      in_vld = 1'b0; x_in = 6'h21; y_in = 5'd3;
      #1;
      chk("R5 comb out_vld low", int'(c_vld), 0);
      @(posedge clk); #1;
      chk("R6 reg out_vld low", int'(r_vld), 0);
      chk("R7 xsq held", int'(r_xsq), px * px);
      chk("R7 ysq held", int'(r_ysq), py * py);
      @(negedge clk);
      x_in = 6'h00; y_in = 5'd0;
      @(posedge clk); #1;
      chk("R7 xsq held again", int'(r_xsq), px * px);
      chk("R7 ysq held again", int'(r_ysq), py * py);

      // R6: one valid pulse after idle
      @(negedge clk);
      in_vld = 1'b1; x_in = 6'h3B; y_in = 5'd9;   // X = -5
      @(posedge clk); #1;
      chk("R2 reg xsq after idle", int'(r_xsq), 25);
      chk("R1 reg ysq after idle", int'(r_ysq), 81);
      @(negedge clk);
      in_vld = 1'b0;
      @(posedge clk); #1;
      chk("R6 reg out_vld drops", int'(r_vld), 0);

      // R8: reset asserted mid-run clears the registered outputs
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk("R8 out_vld after reset", int'(r_vld), 0);
      chk("R8 xsq after reset", int'(r_xsq), 0);
      chk("R8 ysq after reset", int'(r_ysq), 0);

      done = 1'b1;
      finish_run();
   end
endmodule